// File: doc/BRIEF.md
# Asynchronous Memory Bus Timing Engine

This block turns single requests from an internal client (address, write data, byte-lane enables and a read/write flag) into the pin-level sequence for one chip-select bank of an external asynchronous static memory, pseudo-static memory or parallel flash. Each access is made of phases: byte-lane setup, address setup, an optional address hold, data setup, data hold and bus turnaround. The length of each phase in controller clock cycles comes from configuration inputs. Reads and writes have separate timing sets. Only the byte-lane setup value is shared by both.

The bus can be split, with address lines and a data bus, or multiplexed, with the address driven on the data bus while an address-valid strobe is low. A wait input can stretch the data-setup phase. Whether it is used and which level means "wait" are both configurable. The data bus is 16 bits wide, or 8 bits when only the low byte lane is used.

The client sees a ready signal that is high only when the engine is idle. Read data comes back with a single-cycle valid pulse.

Top module: `amem_timing_engine`

## Requirements
- R1: After reset and whenever idle, `req_ready_o` is 1, `mem_cs_no`, `mem_oe_no`, `mem_we_no`, `mem_adv_no` and both bits of `mem_be_no` are 1, and `mem_dq_oe_o` is 0.
- R2: The selected byte-lane enables (`mem_be_no[k]` low for `req_be_i[k]`=1) are low for exactly `cfg_bl_setup_i` cycles with `mem_cs_no` still high. They stay low until the data hold phase ends.
- R3: Chip select is low for exactly address-setup cycles before the strobe (split bus). In multiplexed mode (`cfg_mux_i`=1), `mem_adv_no` is low for exactly those cycles, with `mem_dq_oe_o`=1 and `mem_dq_o` carrying the address low bits.
- R4: In multiplexed mode only, an address-hold phase of the configured length follows address setup, before the strobe. With `cfg_mux_i`=0 the hold value has no effect on any pin.
- R5: The strobe (`mem_oe_no` for reads, `mem_we_no` for writes) is low for max(data setup, 1) cycles. During a write strobe `mem_dq_oe_o`=1 and `mem_dq_o` equals the write data.
- R6: Chip select stays low for exactly data-hold cycles after the strobe rises.
- R7: After chip select rises, `req_ready_o` stays low for exactly the turnaround count. Only then is a new request accepted.
- R8: Writes take address setup, address hold, data setup, data hold and turnaround from the `cfg_wr_*` inputs. Reads take them from the `cfg_rd_*` inputs.
- R9: With `cfg_wait_en_i`=1, every cycle of data setup in which wait is active freezes the count, so the strobe lengthens by the number of active cycles. With `cfg_wait_en_i`=0, the wait input has no effect.
- R10: Wait is active when `mem_wait_i` equals `cfg_wait_pol_i`: 0 selects active-low, 1 selects active-high.
- R11: `cfg_wide_i`=1 selects a 16-bit bus. With 0, `mem_be_no[1]` stays 1, the upper byte of `mem_dq_o` is 0, and the upper byte of `rsp_rdata_o` is 0.
- R12: A read samples `mem_dq_i` in the last data-setup cycle and raises `rsp_valid_o` for one cycle, in the cycle right after the strobe ends. A write raises no `rsp_valid_o`.
- R13: A phase with a zero count is skipped. A zero data setup still gives a one-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle, request accepted this cycle if valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Write data |
| req_be_i | input | LANES | Byte-lane enables, active high |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | DW | Read data |
| cfg_mux_i | input | 1 | Multiplexed address/data bus |
| cfg_wide_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_wait_en_i | input | 1 | Honour the wait input |
| cfg_wait_pol_i | input | 1 | Wait active level |
| cfg_bl_setup_i | input | TW | Byte-lane setup cycles |
| cfg_rd_asu_i | input | TW | Read address setup |
| cfg_rd_ahd_i | input | TW | Read address hold |
| cfg_rd_dsu_i | input | TW | Read data setup |
| cfg_rd_dhd_i | input | TW | Read data hold |
| cfg_rd_trn_i | input | TW | Read turnaround |
| cfg_wr_asu_i | input | TW | Write address setup |
| cfg_wr_ahd_i | input | TW | Write address hold |
| cfg_wr_dsu_i | input | TW | Write data setup |
| cfg_wr_dhd_i | input | TW | Write data hold |
| cfg_wr_trn_i | input | TW | Write turnaround |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_adv_no | output | 1 | Address valid (multiplexed mode), active low |
| mem_be_no | output | LANES | Byte-lane enables, active low |
| mem_addr_o | output | AW | Address lines |
| mem_dq_o | output | DW | Data bus out |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | DW | Data bus in |
| mem_wait_i | input | 1 | Wait from the device |

## Verification
Wait stretching and read capture can fall in the same cycle. A wait level that is active on the last programmed data-setup cycle must hold back the sample and the response. The bench keeps wait active for the first cycles of the strobe and drives a different value on `mem_dq_i` in every strobe cycle. The returned word shows exactly which cycle was sampled, and the expected value is the one from the final cycle after stretching. The same scenario is repeated with wait disabled and the pin still active, and there the sample must come from the unstretched last cycle.

// File: rtl/amem_pkg.sv
package amem_pkg;
  localparam int unsigned TW = 6;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_BLS  = 3'd1,
    PH_ASU  = 3'd2,
    PH_AHD  = 3'd3,
    PH_DSU  = 3'd4,
    PH_DHD  = 3'd5,
    PH_TRN  = 3'd6
  } phase_e;

  typedef struct packed {
    logic [TW-1:0] bls;
    logic [TW-1:0] asu;
    logic [TW-1:0] ahd;
    logic [TW-1:0] dsu;
    logic [TW-1:0] dhd;
    logic [TW-1:0] trn;
  } timing_t;
endpackage

// File: rtl/amem_timing_sel.sv
module amem_timing_sel
  import amem_pkg::*;
(
  input  logic          write_i,
  input  logic          mux_i,
  input  logic [TW-1:0] bls_i,
  input  logic [TW-1:0] rd_asu_i,
  input  logic [TW-1:0] rd_ahd_i,
  input  logic [TW-1:0] rd_dsu_i,
  input  logic [TW-1:0] rd_dhd_i,
  input  logic [TW-1:0] rd_trn_i,
  input  logic [TW-1:0] wr_asu_i,
  input  logic [TW-1:0] wr_ahd_i,
  input  logic [TW-1:0] wr_dsu_i,
  input  logic [TW-1:0] wr_dhd_i,
  input  logic [TW-1:0] wr_trn_i,
  output timing_t       tim_o
);
  logic [TW-1:0] dsu_raw;

  always_comb begin
    dsu_raw    = write_i ? wr_dsu_i : rd_dsu_i;
    tim_o.bls  = bls_i;
    tim_o.asu  = write_i ? wr_asu_i : rd_asu_i;
    // hold only exists on a multiplexed bus
    tim_o.ahd  = mux_i ? (write_i ? wr_ahd_i : rd_ahd_i) : '0;
    tim_o.dsu  = (dsu_raw == '0) ? TW'(1) : dsu_raw;
    tim_o.dhd  = write_i ? wr_dhd_i : rd_dhd_i;
    tim_o.trn  = write_i ? wr_trn_i : rd_trn_i;
  end
endmodule

// File: rtl/amem_phase_seq.sv
module amem_phase_seq
  import amem_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  timing_t tim_i,
  input  logic    hold_i,
  output phase_e  phase_o,
  output logic    last_dsu_o
);
  phase_e        ph_q, nxt;
  logic [TW-1:0] cnt_q, load;
  timing_t       tim_q, t_use;
  logic          stall, done;

  function automatic logic [TW-1:0] len_of(phase_e p, timing_t t);
    case (p)
      PH_BLS:  return t.bls;
      PH_ASU:  return t.asu;
      PH_AHD:  return t.ahd;
      PH_DSU:  return t.dsu;
      PH_DHD:  return t.dhd;
      PH_TRN:  return t.trn;
      default: return '0;
    endcase
  endfunction

  // first non-empty phase after 'from', IDLE when none is left
  function automatic phase_e pick(phase_e from, timing_t t);
    phase_e r;
    logic   found;
    r     = PH_IDLE;
    found = 1'b0;
    for (int k = 1; k < 7; k++) begin
      if (!found && k > int'(from) && len_of(phase_e'(3'(k)), t) != '0) begin
        r     = phase_e'(3'(k));
        found = 1'b1;
      end
    end
    return r;
  endfunction

  always_comb begin
    t_use = (ph_q == PH_IDLE) ? tim_i : tim_q;
    stall = (ph_q == PH_DSU) && hold_i;
    done  = (ph_q != PH_IDLE) && (cnt_q == '0) && !stall;
    nxt   = pick(ph_q, t_use);
    load  = (nxt == PH_IDLE) ? '0 : len_of(nxt, t_use) - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      tim_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      if (start_i) begin
        tim_q <= tim_i;
        ph_q  <= nxt;
        cnt_q <= load;
      end
    end else if (done) begin
      ph_q  <= nxt;
      cnt_q <= load;
    end else if (!stall) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign phase_o    = ph_q;
  assign last_dsu_o = (ph_q == PH_DSU) && done;
endmodule

// File: rtl/amem_pin_drive.sv
module amem_pin_drive
  import amem_pkg::*;
#(
  parameter int unsigned AW    = 24,
  parameter int unsigned LANES = 2,
  localparam int unsigned DW   = 8 * LANES
) (
  input  phase_e           phase_i,
  input  logic             write_i,
  input  logic             mux_i,
  input  logic [LANES-1:0] lane_on_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] be_i,
  output logic             cs_no,
  output logic             oe_no,
  output logic             we_no,
  output logic             adv_no,
  output logic [LANES-1:0] be_no,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o
);
  logic          in_cs, in_lane, addr_ph, data_ph;
  logic [DW-1:0] dmask, raw;

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign dmask[8*l +: 8] = {8{lane_on_i[l]}};
  end

  always_comb begin
    in_cs   = phase_i inside {PH_ASU, PH_AHD, PH_DSU, PH_DHD};
    in_lane = in_cs || (phase_i == PH_BLS);
    addr_ph = mux_i && (phase_i inside {PH_ASU, PH_AHD});
    data_ph = write_i && (phase_i inside {PH_DSU, PH_DHD});
    cs_no   = !in_cs;
    oe_no   = !((phase_i == PH_DSU) && !write_i);
    we_no   = !((phase_i == PH_DSU) && write_i);
    adv_no  = !(mux_i && (phase_i == PH_ASU));
    be_no   = in_lane ? ~(be_i & lane_on_i) : '1;
    addr_o  = addr_i;
    raw     = addr_ph ? addr_i[DW-1:0] : wdata_i;
    dq_o    = raw & dmask;
    dq_oe_o = addr_ph || data_ph;
  end
endmodule

// File: rtl/amem_rd_capture.sv
module amem_rd_capture #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [DW-1:0] dq_i,
  input  logic [DW-1:0] mask_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= take_i;
      if (take_i) data_o <= dq_i & mask_i;
    end
  end
endmodule

// File: rtl/amem_timing_engine.sv
module amem_timing_engine
  import amem_pkg::*;
#(
  parameter int unsigned AW    = 24,
  parameter int unsigned LANES = 2,
  localparam int unsigned DW   = 8 * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic [LANES-1:0] req_be_i,
  output logic             rsp_valid_o,
  output logic [DW-1:0]    rsp_rdata_o,
  input  logic             cfg_mux_i,
  input  logic             cfg_wide_i,
  input  logic             cfg_wait_en_i,
  input  logic             cfg_wait_pol_i,
  input  logic [TW-1:0]    cfg_bl_setup_i,
  input  logic [TW-1:0]    cfg_rd_asu_i,
  input  logic [TW-1:0]    cfg_rd_ahd_i,
  input  logic [TW-1:0]    cfg_rd_dsu_i,
  input  logic [TW-1:0]    cfg_rd_dhd_i,
  input  logic [TW-1:0]    cfg_rd_trn_i,
  input  logic [TW-1:0]    cfg_wr_asu_i,
  input  logic [TW-1:0]    cfg_wr_ahd_i,
  input  logic [TW-1:0]    cfg_wr_dsu_i,
  input  logic [TW-1:0]    cfg_wr_dhd_i,
  input  logic [TW-1:0]    cfg_wr_trn_i,
  output logic             mem_cs_no,
  output logic             mem_oe_no,
  output logic             mem_we_no,
  output logic             mem_adv_no,
  output logic [LANES-1:0] mem_be_no,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_dq_o,
  output logic             mem_dq_oe_o,
  input  logic [DW-1:0]    mem_dq_i,
  input  logic             mem_wait_i
);
  phase_e           phase;
  timing_t          tim;
  logic             accept, hold, last_dsu;
  logic             wr_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q, dmask;
  logic [LANES-1:0] be_q, lane_on;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_on[l]         = cfg_wide_i || (l == 0);
    assign dmask[8*l +: 8]    = {8{lane_on[l]}};
  end

  assign req_ready_o = (phase == PH_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign hold        = cfg_wait_en_i && (mem_wait_i == cfg_wait_pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      wr_q    <= req_write_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      be_q    <= req_be_i;
    end
  end

  amem_timing_sel u_sel (
    .write_i  (req_write_i),
    .mux_i    (cfg_mux_i),
    .bls_i    (cfg_bl_setup_i),
    .rd_asu_i (cfg_rd_asu_i),
    .rd_ahd_i (cfg_rd_ahd_i),
    .rd_dsu_i (cfg_rd_dsu_i),
    .rd_dhd_i (cfg_rd_dhd_i),
    .rd_trn_i (cfg_rd_trn_i),
    .wr_asu_i (cfg_wr_asu_i),
    .wr_ahd_i (cfg_wr_ahd_i),
    .wr_dsu_i (cfg_wr_dsu_i),
    .wr_dhd_i (cfg_wr_dhd_i),
    .wr_trn_i (cfg_wr_trn_i),
    .tim_o    (tim)
  );

  amem_phase_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .tim_i      (tim),
    .hold_i     (hold),
    .phase_o    (phase),
    .last_dsu_o (last_dsu)
  );

  amem_pin_drive #(.AW(AW), .LANES(LANES)) u_pins (
    .phase_i   (phase),
    .write_i   (wr_q),
    .mux_i     (cfg_mux_i),
    .lane_on_i (lane_on),
    .addr_i    (addr_q),
    .wdata_i   (wdata_q),
    .be_i      (be_q),
    .cs_no     (mem_cs_no),
    .oe_no     (mem_oe_no),
    .we_no     (mem_we_no),
    .adv_no    (mem_adv_no),
    .be_no     (mem_be_no),
    .addr_o    (mem_addr_o),
    .dq_o      (mem_dq_o),
    .dq_oe_o   (mem_dq_oe_o)
  );

  amem_rd_capture #(.DW(DW)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (last_dsu && !wr_q),
    .dq_i    (mem_dq_i),
    .mask_i  (dmask),
    .valid_o (rsp_valid_o),
    .data_o  (rsp_rdata_o)
  );
endmodule

// File: rtl/amem_timing_engine_chk.sv
module amem_timing_engine_chk #(
  parameter int unsigned LANES = 2,
  localparam int unsigned DW   = 8 * LANES
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic             cfg_wide_i,
  input logic             mem_cs_no,
  input logic             mem_oe_no,
  input logic             mem_we_no,
  input logic             mem_adv_no,
  input logic [LANES-1:0] mem_be_no,
  input logic [DW-1:0]    mem_dq_o,
  input logic             mem_dq_oe_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_cs_no && mem_oe_no && mem_we_no && mem_adv_no && !mem_dq_oe_o));

  a_r5_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));

  a_r5_strobe_in_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> !mem_cs_no);

  a_r3_adv_in_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_adv_no |-> (!mem_cs_no && mem_dq_oe_o));

  a_r7_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r12_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r12_read_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o);

  a_r11_narrow_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wide_i |-> (mem_be_no[LANES-1] && (!mem_dq_oe_o || mem_dq_o[DW-1 -: 8] == 8'h00)));
endmodule

bind amem_timing_engine amem_timing_engine_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/amem_timing_engine_tb.sv
module amem_timing_engine_tb_top;
  localparam int CLK_P = 10;
  localparam logic [15:0] RD_BASE = 16'hA530;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [1:0]  req_be_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [15:0] rsp_rdata_o;
  logic        cfg_mux = 0, cfg_wide = 1, cfg_wait_en = 0, cfg_wait_pol = 0;
  logic [5:0]  c_bl = 0;
  logic [5:0]  r_asu = 0, r_ahd = 0, r_dsu = 0, r_dhd = 0, r_trn = 0;
  logic [5:0]  w_asu = 0, w_ahd = 0, w_dsu = 0, w_dhd = 0, w_trn = 0;
  logic        mem_cs_no, mem_oe_no, mem_we_no, mem_adv_no, mem_dq_oe_o;
  logic [1:0]  mem_be_no;
  logic [23:0] mem_addr_o;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i = '0;
  logic        mem_wait_i = 1'b1;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  amem_timing_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_be_i(req_be_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .cfg_mux_i(cfg_mux), .cfg_wide_i(cfg_wide), .cfg_wait_en_i(cfg_wait_en),
    .cfg_wait_pol_i(cfg_wait_pol), .cfg_bl_setup_i(c_bl),
    .cfg_rd_asu_i(r_asu), .cfg_rd_ahd_i(r_ahd), .cfg_rd_dsu_i(r_dsu),
    .cfg_rd_dhd_i(r_dhd), .cfg_rd_trn_i(r_trn),
    .cfg_wr_asu_i(w_asu), .cfg_wr_ahd_i(w_ahd), .cfg_wr_dsu_i(w_dsu),
    .cfg_wr_dhd_i(w_dhd), .cfg_wr_trn_i(w_trn),
    .mem_cs_no(mem_cs_no), .mem_oe_no(mem_oe_no), .mem_we_no(mem_we_no),
    .mem_adv_no(mem_adv_no), .mem_be_no(mem_be_no), .mem_addr_o(mem_addr_o),
    .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i),
    .mem_wait_i(mem_wait_i)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // One access, every phase measured at the pins and compared to the config
  task automatic run_txn(input string tag, input logic wr, input logic [23:0] addr,
                         input logic [15:0] wd, input logic [1:0] be, input int waits);
    int bls = 0, pre = 0, adv = 0, st = 0, post = 0, trn = 0, rsp = 0, rsp_ok = 0, bad = 0;
    int wl = waits;
    logic [15:0] got = '0, mask;
    logic st_seen = 0, cs_seen = 0, prev_st = 0;
    int e_asu, e_ahd, e_dsu, e_dhd, e_trn, e_st;
    e_asu = wr ? w_asu : r_asu;
    e_ahd = cfg_mux ? (wr ? w_ahd : r_ahd) : 0;
    e_dsu = wr ? w_dsu : r_dsu;
    if (e_dsu == 0) e_dsu = 1;
    e_dhd = wr ? w_dhd : r_dhd;
    e_trn = wr ? w_trn : r_trn;
    e_st  = e_dsu + (cfg_wait_en ? waits : 0);
    mask  = cfg_wide ? 16'hFFFF : 16'h00FF;
    mem_wait_i = ~cfg_wait_pol;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1; req_write_i = wr; req_addr_i = addr; req_wdata_i = wd; req_be_i = be;
    @(negedge clk);
    req_valid_i = 0;
    for (int i = 0; i < 300; i++) begin
      logic stb;
      stb = wr ? !mem_we_no : !mem_oe_no;
      if (mem_cs_no && mem_be_no != 2'b11 && !cs_seen) bls++;
      if (!mem_cs_no) begin
        cs_seen = 1;
        if (!st_seen && !stb) pre++;
        if (st_seen && !stb) post++;
      end else if (cs_seen && !req_ready_o) trn++;
      if (!mem_adv_no) begin
        adv++;
        if (!mem_dq_oe_o || mem_dq_o != (addr[15:0] & mask)) bad++;
      end
      if (stb) begin
        st++; st_seen = 1;
        if (mem_be_no != ~(be & (cfg_wide ? 2'b11 : 2'b01))) bad++;
        if (wr && (!mem_dq_oe_o || mem_dq_o != (wd & mask))) bad++;
      end
      if (!cfg_wide && !mem_be_no[1]) bad++;
      if (rsp_valid_o) begin
        rsp++; got = rsp_rdata_o;
        if (prev_st && !stb) rsp_ok++;
      end
      if (stb && wl > 0) begin mem_wait_i = cfg_wait_pol; wl--; end
      else mem_wait_i = ~cfg_wait_pol;
      if (stb && !wr) mem_dq_i = RD_BASE + 16'(st - 1);
      prev_st = stb;
      if (req_ready_o) break;
      @(negedge clk);
    end
    chk({tag, " R2 byte-lane setup cycles"}, bls, c_bl);
    chk({tag, " R3 R4 cycles before strobe"}, pre, e_asu + e_ahd);
    chk({tag, " R3 address-valid cycles"}, adv, cfg_mux ? e_asu : 0);
    chk({tag, " R5 R9 strobe cycles"}, st, e_st);
    chk({tag, " R6 data hold cycles"}, post, e_dhd);
    chk({tag, " R7 turnaround cycles"}, trn, e_trn);
    chk({tag, " R5 R11 pin values"}, bad, 0);
    chk({tag, " R12 response pulses"}, rsp, wr ? 0 : 1);
    chk({tag, " R12 response timing"}, rsp_ok, wr ? 0 : 1);
    if (!wr) chk({tag, " R12 read data"}, int'(got), int'((RD_BASE + 16'(e_st - 1)) & mask));
  endtask

  task automatic t_reset();
    chk("R1 ready", req_ready_o, 1);
    chk("R1 strobes idle", {mem_cs_no, mem_oe_no, mem_we_no, mem_adv_no}, 4'hF);
    chk("R1 lanes idle", mem_be_no, 3);
    chk("R1 bus released", mem_dq_oe_o, 0);
    chk("R1 no response", rsp_valid_o, 0);
  endtask

  task automatic t_split_read();
    cfg_mux = 0; cfg_wide = 1; cfg_wait_en = 0; c_bl = 2;
    r_asu = 3; r_ahd = 2; r_dsu = 4; r_dhd = 2; r_trn = 3;
    run_txn("R4 split read", 0, 24'h012345, 16'h0, 2'b11, 0);
  endtask

  task automatic t_write_set();
    c_bl = 1;
    w_asu = 2; w_ahd = 1; w_dsu = 3; w_dhd = 1; w_trn = 2;
    run_txn("R8 split write", 1, 24'h00BEEF, 16'h5AC3, 2'b10, 0);
    run_txn("R8 read after write", 0, 24'h000010, 16'h0, 2'b01, 0);
  endtask

  task automatic t_mux();
    cfg_mux = 1;
    run_txn("R4 mux read", 0, 24'h00C0DE, 16'h0, 2'b11, 0);
    run_txn("R4 mux write", 1, 24'h001234, 16'h9876, 2'b11, 0);
    cfg_mux = 0;
  endtask

  task automatic t_wait();
    cfg_wait_en = 1; cfg_wait_pol = 0;
    run_txn("R9 wait low active", 0, 24'h000100, 16'h0, 2'b11, 3);
    cfg_wait_pol = 1;
    run_txn("R10 wait high active", 1, 24'h000200, 16'h1111, 2'b11, 2);
    run_txn("R10 wait high read", 0, 24'h000300, 16'h0, 2'b11, 1);
    cfg_wait_en = 0;
    run_txn("R9 wait disabled", 0, 24'h000400, 16'h0, 2'b11, 3);
    cfg_wait_pol = 0;
  endtask

  task automatic t_narrow();
    cfg_wide = 0;
    run_txn("R11 narrow read", 0, 24'h000500, 16'h0, 2'b11, 0);
    run_txn("R11 narrow write", 1, 24'h000600, 16'hFE21, 2'b11, 0);
    cfg_mux = 1;
    run_txn("R11 narrow mux read", 0, 24'h00AB77, 16'h0, 2'b11, 0);
    cfg_mux = 0; cfg_wide = 1;
  endtask

  task automatic t_zero();
    c_bl = 0;
    r_asu = 0; r_ahd = 0; r_dsu = 0; r_dhd = 0; r_trn = 0;
    w_asu = 0; w_ahd = 0; w_dsu = 0; w_dhd = 0; w_trn = 0;
    run_txn("R13 zero read", 0, 24'h000700, 16'h0, 2'b11, 0);
    run_txn("R13 zero write", 1, 24'h000800, 16'h4242, 2'b01, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_split_read();
    t_write_set();
    t_mux();
    t_wait();
    t_narrow();
    t_zero();
    repeat (2) @(negedge clk);
    t_reset();
    summary();
  end
endmodule